// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block takes two 32-bit binary floating-point words (one sign bit, an 8-bit biased exponent and a 23-bit fraction with an implied leading one) and returns their product in the same format. A caller places both operands on the inputs and raises `start` for one cycle while `busy` is low. `done` then pulses for one cycle, and at that point `product`, `ovf` and `unf` are valid. They keep their values until the next `done`.

The sign of the product is the exclusive OR of the two operand signs. The exponent is the sum of the two biased exponents less 127. The two 24-bit significands are multiplied by an iterative shift-add engine into a 48-bit product. That product lies in [1, 4), so it needs at most one right shift to normalize. It is then rounded to nearest, with ties going to even, from its round and sticky bits. A rounding carry renormalizes the result.

Some operands take a short path and skip the multiply: zero, infinity, NaN, and words whose exponent field is zero (these are flushed to zero). Their result appears one cycle after `start`. An ordinary multiply takes 25 cycles.

Top module: `fp32_mult_unit`

## Requirements
- R1: `start` is accepted only while `busy` is low. `busy` and `done` are never high together. `done` is high for a single cycle per accepted operation. `product`, `ovf` and `unf` change only in a cycle where `done` is high and otherwise hold their values.
- R2: A `start` raised while `busy` is high is ignored. The running operation completes with its own operands and no second result follows.
- R3: Bit 31 of every non-NaN result equals bit 31 of `opa` XOR bit 31 of `opb`.
- R4: For normal operands, the result exponent field is EA + EB − 127. It gains one more when the significand product is 2 or greater, and in that case the significand is shifted right by one place.
- R5: The 23 kept fraction bits are rounded as follows. R is the first discarded bit and S is the OR of all lower discarded bits. The fraction is incremented when R=1 and S=1. It is truncated when R=0. When R=1 and S=0 (a tie), it is incremented only if its last bit is 1.
- R6: When rounding carries out of the fraction, the fraction becomes zero and the exponent increases by one.
- R7: A final biased exponent of 255 or more gives infinity with the computed sign (exponent field all ones, fraction zero) and `ovf`=1.
- R8: A final biased exponent of 0 or less gives zero with the computed sign and `unf`=1.
- R9: An operand whose exponent field is 0 is treated as zero, whatever its fraction. Zero times a finite value gives zero with the XOR sign, and both flags are 0.
- R10: A NaN operand (exponent field 255, fraction nonzero), or zero times infinity, gives exactly 0x7FC00000 with both flags 0.
- R11: Infinity (exponent field 255, fraction zero) times a nonzero finite value or infinity gives infinity with the XOR sign, and both flags are 0.
- R12: After reset, `busy`, `done`, `ovf` and `unf` are 0 and `product` is 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to multiply the present operands |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| busy | output | 1 | Significand multiply in progress |
| done | output | 1 | One-cycle pulse: result valid |
| product | output | 32 | Rounded product |
| ovf | output | 1 | Result exponent overflowed; product is signed infinity |
| unf | output | 1 | Result exponent underflowed; product is signed zero |

## Verification
Round-to-nearest-even and overflow detection can both act on the same result. This happens when the operands sum to the largest normal exponent, the significand product is exactly a tie just below 2, and its last kept bit is 1. The increment then carries out of the fraction and lifts the exponent to 255. The bench provokes this with operand significands 0x842108 and 0xF80000, exponents 254 and 127. It judges the result correct only if the output is positive infinity with `ovf` set. The same significand pair at exponents 127 and 127 must give exactly 2.0 with no flag.

// File: rtl/fpm_pkg.sv
`timescale 1ns/1ps
// Package fpm_pkg
// Shared format constants and types of the floating-point multiplier.
// Assumes a binary interchange layout: sign, biased exponent, fraction.
package fpm_pkg;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int PROD_W = 2 * SIG_W;
    localparam int XW     = EXP_W + 2;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;

    localparam logic [WORD_W-1:0] QNAN_WORD =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef struct packed {
        logic                  sign;
        logic [EXP_W-1:0]      exp;
        logic [FRAC_W-1:0]     frac;
    } fp_word_t;

    typedef struct packed {
        logic zero;
        logic inf;
        logic nan;
    } fp_class_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } fpm_state_t;
endpackage

// File: rtl/fpm_unpack.sv
`timescale 1ns/1ps
// Module fpm_unpack
// Splits one operand word into sign, exponent and significand with the
// implied one, and classifies it. An exponent field of zero is flushed
// to zero regardless of the fraction. Purely combinational.
module fpm_unpack
    import fpm_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic              sign,
    output logic [EXP_W-1:0]  exp,
    output logic [SIG_W-1:0]  sig,
    output fp_class_t         cls
);
    fp_word_t w;
    logic     exp_ones;
    logic     frac_any;

    assign w = word;

    // Field extraction and classification.
    always_comb begin
        exp_ones = &w.exp;
        frac_any = |w.frac;
        sign     = w.sign;
        exp      = w.exp;
        sig      = {1'b1, w.frac};
        cls.zero = (w.exp == '0);
        cls.inf  = exp_ones & ~frac_any;
        cls.nan  = exp_ones & frac_any;
    end
endmodule

// File: rtl/fpm_sigmul.sv
`timescale 1ns/1ps
// Module fpm_sigmul
// Iterative unsigned shift-add multiplier. A pulse on go loads the
// operands; W steps later fin pulses once with the full 2W-bit product
// on prod, which then holds until the next go. go while active restarts.
module fpm_sigmul #(
    parameter int W = 24
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic           fin,
    output logic [2*W-1:0] prod
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [2*W-1:0] mcand;
    logic [W-1:0]   mplier;
    logic [2*W-1:0] acc;
    logic [CW-1:0]  cnt;
    logic           active;
    logic           fin_q;

    // One partial product per cycle: add, then shift both operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand  <= '0;
            mplier <= '0;
            acc    <= '0;
            cnt    <= '0;
            active <= 1'b0;
            fin_q  <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (go) begin
                acc    <= '0;
                mcand  <= {{W{1'b0}}, a};
                mplier <= b;
                cnt    <= '0;
                active <= 1'b1;
            end else if (active) begin
                if (mplier[0]) begin
                    acc <= acc + mcand;
                end
                mcand  <= mcand << 1;
                mplier <= mplier >> 1;
                cnt    <= cnt + 1'b1;
                if (cnt == LAST) begin
                    active <= 1'b0;
                    fin_q  <= 1'b1;
                end
            end
        end
    end

    assign fin  = fin_q;
    assign prod = acc;
endmodule

// File: rtl/fpm_round.sv
`timescale 1ns/1ps
// Module fpm_round
// Turns a raw significand product and two biased exponents into a packed
// result: one-place normalization, round to nearest even, renormalization
// on carry, then exponent range check. Assumes both operands were normal.
module fpm_round
    import fpm_pkg::*;
(
    input  logic              sign,
    input  logic [EXP_W-1:0]  ea,
    input  logic [EXP_W-1:0]  eb,
    input  logic [PROD_W-1:0] prod,
    output logic [WORD_W-1:0] result,
    output logic              ovf,
    output logic              unf
);
    localparam logic [XW-1:0] BIAS_X = XW'(BIAS);
    localparam logic [XW-1:0] MAX_X  = XW'((1 << EXP_W) - 1);
    localparam logic [XW-1:0] ONE_X  = XW'(1);

    logic [XW-1:0]     esum;
    logic              hi;
    logic [PROD_W-1:0] norm;
    logic [FRAC_W-1:0] frac;
    logic              rbit;
    logic              sticky;
    logic              inc;
    logic [FRAC_W:0]   rsum;
    logic              carry;
    logic [XW-1:0]     efin;

    // Exponent sum in extended width, so both range ends stay visible.
    always_comb begin
        esum = {2'b00, ea} + {2'b00, eb} - BIAS_X;
    end

    // Normalize by at most one place and pick round and sticky bits.
    always_comb begin
        hi     = prod[PROD_W-1];
        norm   = hi ? prod : {prod[PROD_W-2:0], 1'b0};
        frac   = norm[PROD_W-2 -: FRAC_W];
        rbit   = norm[PROD_W-2-FRAC_W];
        sticky = |norm[PROD_W-3-FRAC_W:0];
    end

    // Nearest-even increment and carry-out renormalization.
    always_comb begin
        inc   = rbit & (sticky | frac[0]);
        rsum  = {1'b0, frac} + {{FRAC_W{1'b0}}, inc};
        carry = rsum[FRAC_W];
        efin  = esum + {{(XW-1){1'b0}}, hi} + {{(XW-1){1'b0}}, carry};
    end

    // Range check and packing of the final word.
    always_comb begin
        ovf = ($signed(efin) >= $signed(MAX_X));
        unf = ($signed(efin) <  $signed(ONE_X));
        if (ovf) begin
            result = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else if (unf) begin
            result = {sign, {EXP_W{1'b0}}, {FRAC_W{1'b0}}};
        end else begin
            result = {sign, efin[EXP_W-1:0], rsum[FRAC_W-1:0]};
        end
    end
endmodule

// File: rtl/fp32_mult_unit.sv
`timescale 1ns/1ps
// Module fp32_mult_unit
// Single-precision multiplier with a start/done handshake. Special
// operands (zero, flushed subnormal, infinity, NaN) resolve in one cycle;
// others go through the iterative significand multiplier and the rounder.
// Assumes start is a request sampled only while busy is low.
module fp32_mult_unit
    import fpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] product,
    output logic              ovf,
    output logic              unf
);
    logic [WORD_W-1:0] op_word [2];
    logic              op_sign [2];
    logic [EXP_W-1:0]  op_exp  [2];
    logic [SIG_W-1:0]  op_sig  [2];
    fp_class_t         op_cls  [2];

    assign op_word[0] = opa;
    assign op_word[1] = opb;

    // One unpacker per operand.
    for (genvar gi = 0; gi < 2; gi++) begin : g_unpack
        fpm_unpack u_unpack (
            .word (op_word[gi]),
            .sign (op_sign[gi]),
            .exp  (op_exp[gi]),
            .sig  (op_sig[gi]),
            .cls  (op_cls[gi])
        );
    end

    fpm_state_t        state;
    logic              sign_q;
    logic [EXP_W-1:0]  ea_q;
    logic [EXP_W-1:0]  eb_q;
    logic [WORD_W-1:0] product_q;
    logic              ovf_q;
    logic              unf_q;
    logic              done_q;

    logic              res_sign;
    logic              any_nan;
    logic              any_inf;
    logic              any_zero;
    logic              special;
    logic [WORD_W-1:0] spec_word;
    logic              accept;
    logic              mul_go;
    logic              mul_fin;
    logic [PROD_W-1:0] mul_prod;
    logic [WORD_W-1:0] rnd_word;
    logic              rnd_ovf;
    logic              rnd_unf;

    // Special-operand resolution, NaN taking priority over infinity.
    always_comb begin
        res_sign = op_sign[0] ^ op_sign[1];
        any_nan  = op_cls[0].nan | op_cls[1].nan
                 | (op_cls[0].zero & op_cls[1].inf)
                 | (op_cls[0].inf  & op_cls[1].zero);
        any_inf  = op_cls[0].inf  | op_cls[1].inf;
        any_zero = op_cls[0].zero | op_cls[1].zero;
        special  = any_nan | any_inf | any_zero;
        if (any_nan) begin
            spec_word = QNAN_WORD;
        end else if (any_inf) begin
            spec_word = {res_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else begin
            spec_word = {res_sign, {EXP_W{1'b0}}, {FRAC_W{1'b0}}};
        end
    end

    // Handshake decode.
    always_comb begin
        accept = start & (state == ST_IDLE);
        mul_go = accept & ~special;
    end

    fpm_sigmul #(.W(SIG_W)) u_sigmul (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (mul_go),
        .a     (op_sig[0]),
        .b     (op_sig[1]),
        .fin   (mul_fin),
        .prod  (mul_prod)
    );

    fpm_round u_round (
        .sign   (sign_q),
        .ea     (ea_q),
        .eb     (eb_q),
        .prod   (mul_prod),
        .result (rnd_word),
        .ovf    (rnd_ovf),
        .unf    (rnd_unf)
    );

    // Control sequence and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            sign_q    <= 1'b0;
            ea_q      <= '0;
            eb_q      <= '0;
            product_q <= '0;
            ovf_q     <= 1'b0;
            unf_q     <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        sign_q <= res_sign;
                        ea_q   <= op_exp[0];
                        eb_q   <= op_exp[1];
                        if (special) begin
                            product_q <= spec_word;
                            ovf_q     <= 1'b0;
                            unf_q     <= 1'b0;
                            done_q    <= 1'b1;
                        end else begin
                            state <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    if (mul_fin) begin
                        product_q <= rnd_word;
                        ovf_q     <= rnd_ovf;
                        unf_q     <= rnd_unf;
                        done_q    <= 1'b1;
                        state     <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (state == ST_RUN);
    assign done    = done_q;
    assign product = product_q;
    assign ovf     = ovf_q;
    assign unf     = unf_q;
endmodule

// File: rtl/fp32_mult_chk.sv
`timescale 1ns/1ps
// Module fp32_mult_chk
// Port-level property checker for fp32_mult_unit. It keeps its own copy
// of the accepted operands to judge sign and NaN results.
module fp32_mult_chk
    import fpm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [WORD_W-1:0] opa,
    input logic [WORD_W-1:0] opb,
    input logic              busy,
    input logic              done,
    input logic [WORD_W-1:0] product,
    input logic              ovf,
    input logic              unf
);
    logic [WORD_W-1:0] cap_a;
    logic [WORD_W-1:0] cap_b;
    logic              cap_nan;

    // Operand capture on every accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_a <= '0;
            cap_b <= '0;
        end else if (start && !busy) begin
            cap_a <= opa;
            cap_b <= opb;
        end
    end

    // Independent NaN expectation from the captured words.
    always_comb begin
        cap_nan = ((&cap_a[30:23]) && (|cap_a[22:0]))
               || ((&cap_b[30:23]) && (|cap_b[22:0]))
               || ((cap_a[30:23] == 8'h00) && (cap_b[30:0] == 31'h7F800000))
               || ((cap_b[30:23] == 8'h00) && (cap_a[30:0] == 31'h7F800000));
    end

    a_r1_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    a_r1_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(product));

    a_r3_sign_xor: assert property (@(posedge clk) disable iff (!rst_n)
        (done && product != QNAN_WORD) |-> (product[31] == (cap_a[31] ^ cap_b[31])));

    a_r10_nan_canonical: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_nan) |-> (product == QNAN_WORD));

    a_r7_ovf_is_inf: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ovf) |-> (product[30:0] == 31'h7F800000));

    a_r8_unf_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && unf) |-> (product[30:0] == 31'h0));

    a_r7_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf && unf));
endmodule

bind fp32_mult_unit fp32_mult_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .opa     (opa),
    .opb     (opb),
    .busy    (busy),
    .done    (done),
    .product (product),
    .ovf     (ovf),
    .unf     (unf)
);

// File: tb/fp32_mult_unit_test.sv
`timescale 1ns/1ps
// Directed bench for fp32_mult_unit: one task per scenario.
module fp32_mult_unit_test;
    localparam int WD_LIMIT = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        busy;
    logic        done;
    logic [31:0] product;
    logic        ovf;
    logic        unf;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;

    fp32_mult_unit uut (
        .clk (clk), .rst_n (rst_n), .start (start), .opa (opa), .opb (opb),
        .busy (busy), .done (done), .product (product), .ovf (ovf), .unf (unf)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        wait (cyc >= WD_LIMIT);
        n_bad++;
        $display("FAIL R1 watchdog: cycles %0d expected below %0d", cyc, WD_LIMIT);
        summary();
        $finish;
    end

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Issue one request and wait for done; sampled at falling edges.
    task automatic issue(logic [31:0] a, logic [31:0] b);
        @(negedge clk);
        opa = a; opb = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 100 && !done; k++) @(negedge clk);
    endtask

    task automatic expect_op(string tag, logic [31:0] a, logic [31:0] b,
                             logic [31:0] exp_w, logic exp_o, logic exp_u);
        issue(a, b);
        chk("R1", "done seen", {31'b0, done}, 32'd1);
        chk(tag, "product", product, exp_w);
        chk(tag, "ovf", {31'b0, ovf}, {31'b0, exp_o});
        chk(tag, "unf", {31'b0, unf}, {31'b0, exp_u});
        @(negedge clk);
        chk("R1", "done single cycle", {31'b0, done}, 32'd0);
        chk("R1", "product held", product, exp_w);
    endtask

    task automatic t_reset();
        chk("R12", "busy", {31'b0, busy}, 32'd0);
        chk("R12", "done", {31'b0, done}, 32'd0);
        chk("R12", "product", product, 32'h0);
        chk("R12", "flags", {30'b0, ovf, unf}, 32'd0);
    endtask

    task automatic t_basic();
        expect_op("R4", 32'h40000000, 32'h40400000, 32'h40C00000, 1'b0, 1'b0); // 2*3
        expect_op("R4", 32'h3FC00000, 32'h3FC00000, 32'h40100000, 1'b0, 1'b0); // 1.5^2 shift
        expect_op("R3", 32'hC0000000, 32'h40400000, 32'hC0C00000, 1'b0, 1'b0);
        expect_op("R3", 32'hBF800000, 32'hBF800000, 32'h3F800000, 1'b0, 1'b0);
        expect_op("R4", 32'h7F000000, 32'h3F800000, 32'h7F000000, 1'b0, 1'b0); // exp 254 kept
    endtask

    task automatic t_round();
        expect_op("R5", 32'hBDE840A1, 32'h3EC01000, 32'hBD2E3EFD, 1'b0, 1'b0); // R=1,S=1 up
        expect_op("R5", 32'h3F800001, 32'h3FC00000, 32'h3FC00002, 1'b0, 1'b0); // tie, odd -> up
        expect_op("R5", 32'h3F800003, 32'h3FC00000, 32'h3FC00004, 1'b0, 1'b0); // tie, even -> keep
        expect_op("R5", 32'h3F800001, 32'h3F800001, 32'h3F800002, 1'b0, 1'b0); // R=0 truncate
    endtask

    task automatic t_carry();
        expect_op("R6", 32'h3F842108, 32'h3FF80000, 32'h40000000, 1'b0, 1'b0);
    endtask

    task automatic t_overflow();
        expect_op("R7", 32'h7F000000, 32'h40000000, 32'h7F800000, 1'b1, 1'b0);
        expect_op("R7", 32'hFF000000, 32'h40000000, 32'hFF800000, 1'b1, 1'b0);
        // rounding carry and overflow on the same result
        expect_op("R7", 32'h7F042108, 32'h3FF80000, 32'h7F800000, 1'b1, 1'b0);
    endtask

    task automatic t_underflow();
        expect_op("R8", 32'h00800000, 32'h3F000000, 32'h00000000, 1'b0, 1'b1);
        expect_op("R8", 32'h80800000, 32'h3F000000, 32'h80000000, 1'b0, 1'b1);
        expect_op("R8", 32'h00800000, 32'h3F800000, 32'h00800000, 1'b0, 1'b0);
    endtask

    task automatic t_zero();
        expect_op("R9", 32'h00400000, 32'h40000000, 32'h00000000, 1'b0, 1'b0);
        expect_op("R9", 32'h80000001, 32'h40000000, 32'h80000000, 1'b0, 1'b0);
        expect_op("R9", 32'h00000000, 32'hC0400000, 32'h80000000, 1'b0, 1'b0);
    endtask

    task automatic t_nan();
        expect_op("R10", 32'h7FC00001, 32'h3F800000, 32'h7FC00000, 1'b0, 1'b0);
        expect_op("R10", 32'h00000000, 32'h7F800000, 32'h7FC00000, 1'b0, 1'b0);
        expect_op("R10", 32'hFF800000, 32'hFF800001, 32'h7FC00000, 1'b0, 1'b0);
    endtask

    task automatic t_inf();
        expect_op("R11", 32'h7F800000, 32'hC0000000, 32'hFF800000, 1'b0, 1'b0);
        expect_op("R11", 32'hFF800000, 32'hFF800000, 32'h7F800000, 1'b0, 1'b0);
    endtask

    task automatic t_busy_start();
        int extra;
        @(negedge clk);
        opa = 32'h40000000; opb = 32'h40400000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R2", "busy during multiply", {31'b0, busy}, 32'd1);
        opa = 32'h3FC00000; opb = 32'h3FC00000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 100 && !done; k++) @(negedge clk);
        chk("R2", "first result kept", product, 32'h40C00000);
        extra = 0;
        @(negedge clk);
        for (int k = 0; k < 40; k++) begin
            if (done) extra++;
            @(negedge clk);
        end
        chk("R2", "no second done", extra, 32'd0);
        chk("R1", "product held idle", product, 32'h40C00000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_round();
        t_carry();
        t_overflow();
        t_underflow();
        t_zero();
        t_nan();
        t_inf();
        t_busy_start();
        summary();
        $finish;
    end
endmodule